// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block makes the SCL waveform for an I2C master from the system clock. A programmable prescaler first divides the system clock into a slower count rate. Two counts then set how long SCL stays low and how long it is released high. Each phase also gets a fixed extra delay term. That term is 7, 6 or 5 count steps, and which one applies depends on the prescaler value. A high count of zero stops clock generation, and SCL then rests released.

The SCL line is sensed back from the bus. During the released phase, a low reading means another device is holding the clock low. While that lasts the high-phase count pauses. The block gives a one-cycle tick at every SCL edge it makes, so a bus engine can place its SDA changes. New prescaler and count values are taken in only at the start of a period, at the falling edge, so a period is never built from mixed settings.

Top module: `scl_timing_gen`

## Requirements
- R1: Without stretching, the low phase lasts exactly (psc + 1) * (lowCnt + d) system clock cycles. Here psc, lowCnt and d are the values captured at the start of that period.
- R2: Without stretching, the released (high) phase lasts exactly (psc + 1) * (highCnt + d) system clock cycles.
- R3: The extra delay d is 7 when psc = 0, 6 when psc = 1, and 5 when psc is 2 or more.
- R4: If highCnt is zero when a period would start, SCL stays released and no tick is made for as long as highCnt stays zero. Once highCnt becomes nonzero, generation resumes with a low phase.
- R5: When enable is low, SCL is released (sclDriveLow = 0) from the first edge on which enable is sampled low, and no tick is made. When enable is sampled high from the stopped state, the low phase begins on that same edge.
- R6: During the released phase, each cycle in which sclIn reads 0 adds one cycle to that phase's length.
- R7: A change to psc, lowCnt or highCnt made during a period does not affect that period. It applies from the next falling edge.
- R8: fallTick is 1 for exactly the first cycle in which sclDriveLow is 1. riseTick is 1 for exactly the first released cycle after a low phase.
- R9: After reset, sclDriveLow, fallTick and riseTick are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request for the generator |
| pscIn | input | PSC_W | Prescaler value; count rate is clk / (pscIn + 1) |
| lowCntIn | input | CNT_W | Low-phase count, before the extra delay is added |
| highCntIn | input | CNT_W | High-phase count; zero stops generation |
| sclIn | input | 1 | SCL level read back from the bus |
| sclDriveLow | output | 1 | 1 pulls SCL low; 0 releases it |
| fallTick | output | 1 | One-cycle pulse on the first cycle of a low phase |
| riseTick | output | 1 | One-cycle pulse on the first cycle of a released phase |

## Verification
Every output is a register. A falling edge and its fallTick both appear in the cycle after the edge on which the state machine decides to start a low phase. The same holds for a rising edge and riseTick. The bench samples once per cycle on the falling clock edge. It counts consecutive driven-low and released samples between ticks, so each phase length is checked to the cycle against (psc + 1) * (count + d). Register changes, stretching and enable changes are all applied on a falling clock edge. Their effect is expected at the next sample, or in the period after the one under way.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  // Strobes passed from the phase controller to the divider datapath.
  typedef struct packed {
    logic load;     // capture prescaler and counts into shadows
    logic clr;      // zero both counters
    logic adv;      // allow counting this cycle
    logic selHigh;  // compare against the high-phase target
  } divStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PARK = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } sclState_t;

  // Extra count steps added to each phase, chosen by the prescaler value.
  function automatic logic [2:0] extraDelay(input logic [31:0] psc);
    if (psc == 32'd0)      extraDelay = 3'd7;
    else if (psc == 32'd1) extraDelay = 3'd6;
    else                   extraDelay = 3'd5;
  endfunction

endpackage

// File: rtl/scl_div_datapath.sv
module scl_div_datapath
  import scl_timing_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       stb,
  input  logic [PSC_W-1:0] pscIn,
  input  logic [CNT_W-1:0] lowCntIn,
  input  logic [CNT_W-1:0] highCntIn,
  output logic             phaseDone,
  output logic             highZeroIn
);
  localparam int TGT_W = CNT_W + 1;

  logic [PSC_W-1:0] pscShadow;
  logic [CNT_W-1:0] lowShadow;
  logic [CNT_W-1:0] highShadow;
  logic [2:0]       delayShadow;
  logic [PSC_W-1:0] psCnt;
  logic [TGT_W-1:0] phCnt;
  logic [TGT_W-1:0] phaseTarget;
  logic             psWrap;

  assign highZeroIn  = (highCntIn == '0);
  assign phaseTarget = TGT_W'(stb.selHigh ? highShadow : lowShadow) + TGT_W'(delayShadow);
  assign psWrap      = (psCnt == pscShadow);
  assign phaseDone   = psWrap && (phCnt == phaseTarget - TGT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscShadow   <= '0;
      lowShadow   <= '0;
      highShadow  <= '0;
      delayShadow <= 3'd7;
    end else if (stb.load) begin
      pscShadow   <= pscIn;
      lowShadow   <= lowCntIn;
      highShadow  <= highCntIn;
      delayShadow <= extraDelay(32'(pscIn));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
      phCnt <= '0;
    end else if (stb.clr) begin
      psCnt <= '0;
      phCnt <= '0;
    end else if (stb.adv) begin
      if (psWrap) begin
        psCnt <= '0;
        phCnt <= phCnt + TGT_W'(1);
      end else begin
        psCnt <= psCnt + PSC_W'(1);
      end
    end
  end

  // R1 R2: the prescale counter never passes its captured limit
  assert_prescale_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    psCnt <= pscShadow);

  // R6: with no clear and no advance, both counters hold their values
  assert_counter_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clr && !stb.adv) |=> ($stable(psCnt) && $stable(phCnt)));

  // R7: shadows change only on a load strobe
  assert_shadow_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(lowShadow) && $stable(highShadow) && $stable(pscShadow)));

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sclIn,
  input  logic       phaseDone,
  input  logic       highZeroIn,
  output divStrobe_t stb,
  output logic       sclDriveLow,
  output logic       fallTick,
  output logic       riseTick
);
  sclState_t state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    if (!enable) begin
      nextState = ST_IDLE;
      stb.clr   = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE, ST_PARK: begin
          stb.load  = 1'b1;
          stb.clr   = 1'b1;
          nextState = highZeroIn ? ST_PARK : ST_LOW;
        end
        ST_LOW: begin
          stb.adv = 1'b1;
          if (phaseDone) begin
            stb.clr   = 1'b1;
            nextState = ST_HIGH;
          end
        end
        ST_HIGH: begin
          stb.selHigh = 1'b1;
          stb.adv     = sclIn;
          if (sclIn && phaseDone) begin
            stb.load  = 1'b1;
            stb.clr   = 1'b1;
            nextState = highZeroIn ? ST_PARK : ST_LOW;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fallTick <= 1'b0;
      riseTick <= 1'b0;
    end else begin
      state    <= nextState;
      fallTick <= (nextState == ST_LOW) && (state != ST_LOW);
      riseTick <= (state == ST_LOW) && (nextState == ST_HIGH);
    end
  end

  assign sclDriveLow = (state == ST_LOW);

  // R5: a sampled low enable leaves SCL released on the next cycle
  assert_disable_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !fallTick && !riseTick));

  // R6: a low sclIn during the released phase keeps the phase going
  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && state == ST_HIGH && !sclIn) |=> (state == ST_HIGH));

  // R8: ticks never coincide
  assert_tick_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(fallTick && riseTick));

  // R8: SCL starting to be driven low comes with a fall tick
  assert_fall_tick_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> fallTick);

  // R4: while parked SCL stays released
  assert_park_released_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARK) |-> (!sclDriveLow && !riseTick));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [PSC_W-1:0] pscIn,
  input  logic [CNT_W-1:0] lowCntIn,
  input  logic [CNT_W-1:0] highCntIn,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             fallTick,
  output logic             riseTick
);
  divStrobe_t stb;
  logic       phaseDone;
  logic       highZeroIn;

  scl_phase_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sclIn      (sclIn),
    .phaseDone  (phaseDone),
    .highZeroIn (highZeroIn),
    .stb        (stb),
    .sclDriveLow(sclDriveLow),
    .fallTick   (fallTick),
    .riseTick   (riseTick)
  );

  scl_div_datapath #(
    .PSC_W(PSC_W),
    .CNT_W(CNT_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pscIn     (pscIn),
    .lowCntIn  (lowCntIn),
    .highCntIn (highCntIn),
    .phaseDone (phaseDone),
    .highZeroIn(highZeroIn)
  );

endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  localparam int PSC_W = 8;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [PSC_W-1:0] pscIn = '0;
  logic [CNT_W-1:0] lowCntIn = '0;
  logic [CNT_W-1:0] highCntIn = '0;
  logic             stretch = 1'b0;
  logic             sclIn;
  logic             sclDriveLow, fallTick, riseTick;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  assign sclIn = !sclDriveLow && !stretch;

  scl_timing_gen #(.PSC_W(PSC_W), .CNT_W(CNT_W)) i_scl_timing_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .pscIn(pscIn),
    .lowCntIn(lowCntIn), .highCntIn(highCntIn), .sclIn(sclIn),
    .sclDriveLow(sclDriveLow), .fallTick(fallTick), .riseTick(riseTick)
  );

  function automatic int expD(input int psc);
    return (psc == 0) ? 7 : ((psc == 1) ? 6 : 5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sync to a period start, then count the low and released samples.
  task automatic measure(input int stretchCyc, input bit doChange,
                         input int newLow, input int newHigh,
                         output int lo, output int hi, output bit tickOk);
    do @(negedge clk); while (!fallTick);
    tickOk = sclDriveLow;
    lo = 1;
    if (doChange) begin
      lowCntIn  = CNT_W'(newLow);
      highCntIn = CNT_W'(newHigh);
    end
    @(negedge clk);
    while (sclDriveLow) begin
      lo++;
      @(negedge clk);
    end
    tickOk = tickOk && riseTick;
    hi = 1;
    stretch = (hi <= stretchCyc);
    @(negedge clk);
    while (!sclDriveLow) begin
      hi++;
      stretch = (hi <= stretchCyc);
      @(negedge clk);
    end
    stretch = 1'b0;
    tickOk = tickOk && fallTick;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int lo, hi, tickCount, driveCount;
    bit tickOk;
    int lows[3]  = '{0, 1, 3};
    int highs[3] = '{1, 2, 4};

    repeat (3) @(negedge clk);
    // R9: reset state
    check(!sclDriveLow && !fallTick && !riseTick, "R9 reset outputs", int'(sclDriveLow), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!sclDriveLow, "R9 idle after reset", int'(sclDriveLow), 0);

    // R1 R2 R3 R8: sweep over prescaler and counts
    enable = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int li = 0; li < 3; li++) begin
        for (int hj = 0; hj < 3; hj++) begin
          pscIn = PSC_W'(p);
          lowCntIn = CNT_W'(lows[li]);
          highCntIn = CNT_W'(highs[hj]);
          measure(0, 1'b0, 0, 0, lo, hi, tickOk);
          measure(0, 1'b0, 0, 0, lo, hi, tickOk);
          check(lo == (p + 1) * (lows[li] + expD(p)), "R1 R3 low length", lo, (p + 1) * (lows[li] + expD(p)));
          check(hi == (p + 1) * (highs[hj] + expD(p)), "R2 R3 high length", hi, (p + 1) * (highs[hj] + expD(p)));
          check(tickOk, "R8 edge ticks", int'(tickOk), 1);
        end
      end
    end

    // R3: a larger prescaler still uses d = 5
    pscIn = PSC_W'(9); lowCntIn = CNT_W'(2); highCntIn = CNT_W'(1);
    measure(0, 1'b0, 0, 0, lo, hi, tickOk);
    measure(0, 1'b0, 0, 0, lo, hi, tickOk);
    check(lo == 10 * 7, "R3 psc9 low", lo, 70);
    check(hi == 10 * 6, "R3 psc9 high", hi, 60);

    // R7: a change made mid-period waits for the next falling edge
    pscIn = PSC_W'(1); lowCntIn = CNT_W'(2); highCntIn = CNT_W'(3);
    measure(0, 1'b0, 0, 0, lo, hi, tickOk);
    measure(0, 1'b1, 10, 1, lo, hi, tickOk);
    check(lo == 2 * 8, "R7 old low kept", lo, 16);
    check(hi == 2 * 9, "R7 old high kept", hi, 18);
    measure(0, 1'b0, 0, 0, lo, hi, tickOk);
    check(lo == 2 * 16, "R7 new low applied", lo, 32);
    check(hi == 2 * 7, "R7 new high applied", hi, 14);

    // R6: stretching lengthens the released phase cycle for cycle
    pscIn = PSC_W'(0); lowCntIn = CNT_W'(1); highCntIn = CNT_W'(2);
    measure(5, 1'b0, 0, 0, lo, hi, tickOk);
    check(hi == 9 + 5, "R6 stretch 5", hi, 14);
    pscIn = PSC_W'(2);
    measure(0, 1'b0, 0, 0, lo, hi, tickOk);
    measure(13, 1'b0, 0, 0, lo, hi, tickOk);
    check(hi == 3 * 7 + 13, "R6 stretch 13", hi, 34);
    check(lo == 3 * 6, "R6 low unaffected", lo, 18);

    // R4: zero high count parks SCL released with no ticks
    highCntIn = '0;
    repeat (80) @(negedge clk);
    tickCount = 0; driveCount = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      tickCount += int'(fallTick) + int'(riseTick);
      driveCount += int'(sclDriveLow);
    end
    check(tickCount == 0, "R4 no ticks while parked", tickCount, 0);
    check(driveCount == 0, "R4 released while parked", driveCount, 0);
    highCntIn = CNT_W'(2);
    @(negedge clk);
    check(sclDriveLow && fallTick, "R4 resume with low phase", int'(sclDriveLow), 1);
    measure(0, 1'b0, 0, 0, lo, hi, tickOk);
    check(lo == 3 * 6 && hi == 3 * 7, "R4 resumed period", lo + hi, 39);

    // R5: disable releases at once, re-enable starts a low phase at once
    do @(negedge clk); while (!sclDriveLow);
    enable = 1'b0;
    @(negedge clk);
    check(!sclDriveLow && !riseTick && !fallTick, "R5 release on disable", int'(sclDriveLow), 0);
    tickCount = 0; driveCount = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      tickCount += int'(fallTick) + int'(riseTick);
      driveCount += int'(sclDriveLow);
    end
    check(tickCount == 0 && driveCount == 0, "R5 quiet while disabled", tickCount + driveCount, 0);
    pscIn = PSC_W'(0); lowCntIn = CNT_W'(0); highCntIn = CNT_W'(1);
    enable = 1'b1;
    @(negedge clk);
    check(sclDriveLow && fallTick, "R5 start on enable", int'(sclDriveLow), 1);
    lo = 1;
    @(negedge clk);
    while (sclDriveLow) begin lo++; @(negedge clk); end
    check(lo == 7, "R5 R1 first low after enable", lo, 7);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule